// File: doc/BRIEF.md
# Reloadable Up-Counting Event Timer

This block is a register-mapped up-counter that serves two purposes. It can deliver an event after a chosen number of ticks, and it can run as a free-running time base. The counter advances by one on each cycle where the tick input is high and the timer is running. An overflow event fires when a tick arrives while the counter holds all-ones. In one-shot mode the timer then stops. In auto-reload mode the counter takes the programmed start value again and keeps counting.

Software controls the timer through five word registers. It writes the start value on its own, then issues a control write that carries a trigger flag. That write copies the start value into the counter and sets the run and reload bits together. To get a delay of N ticks, software loads all-ones minus N. For a period of P ticks, it loads all-ones minus (P-1). The counter copy made by a trigger is clamped, so that the shortest programmed delay is never below a minimum set by a parameter. The overflow flag is cleared by writing a one to it. It drives the interrupt output only while its enable bit is set.

Top module: `evt_timer32`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low. The register map is CTRL at address 0, LOAD at 1, COUNT at 2, STATUS at 3 and IEN at 4. Other addresses read zero.
- R2: While the run bit (CTRL bit 0) is set, each cycle with `tick_i` high adds one to COUNT. While run is clear, ticks have no effect. A CTRL write that clears run freezes COUNT and leaves LOAD and STATUS unchanged.
- R3: A tick while COUNT is all-ones is an overflow and sets STATUS bit 0. A counter started from all-ones minus N overflows on tick N+1.
- R4: With the reload bit (CTRL bit 1) clear, an overflow leaves COUNT at zero and clears the run bit. Later ticks do not move COUNT.
- R5: With the reload bit set, an overflow copies LOAD into COUNT and run stays set. A start value of all-ones minus (P-1) gives one overflow every P ticks.
- R6: A write to LOAD alone changes neither COUNT nor CTRL.
- R7: A CTRL write with bit 2 (trigger) set copies LOAD into COUNT and takes run and reload from bits 0 and 1 of the same write. The trigger bit always reads back as zero.
- R8: The copy made by a trigger is clamped to at most all-ones minus MIN_DELTA (default 3). The LOAD register keeps the value that was written.
- R9: Writing 1 to STATUS bit 0 clears it. Writing 0 has no effect. An overflow in the same cycle as the clearing write leaves the bit set.
- R10: `irq_o` is high exactly when STATUS bit 0 and IEN bit 0 are both set. It stays high until the status bit is cleared or the enable bit is dropped.
- R11: COUNT can be written directly and read at any time, including while running. Started with LOAD 0 and reload set, the timer wraps to zero and keeps counting as a free-running time base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one count per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench times overflow against the tick count. A design that flags overflow when the counter reaches all-ones, instead of when it leaves all-ones, produces the one-shot event one tick early and shortens every period by one. The bench also runs a one-shot after an overflow. If the run bit is not cleared there, the counter keeps moving. If the design reloads in one-shot mode, COUNT reads the start value instead of zero. Two further cases are checked: a clearing write to STATUS in the same cycle as an overflow, which must keep the new flag, and a start value inside the minimum window, which a design without the clamp would copy unchanged.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL   = 3'd0,
      A_LOAD   = 3'd1,
      A_COUNT  = 3'd2,
      A_STATUS = 3'd3,
      A_IEN    = 3'd4
   } reg_addr_e;

   localparam int CTRL_RUN_BIT    = 0;
   localparam int CTRL_RELOAD_BIT = 1;
   localparam int CTRL_TRIG_BIT   = 2;
   localparam int STAT_OVF_BIT    = 0;
   localparam int IEN_OVF_BIT     = 0;
endpackage

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
   parameter int CNT_W     = 32,
   parameter int MIN_DELTA = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             ctrl_we_i,
   input  logic             run_wdata_i,
   input  logic             trig_i,
   input  logic             cnt_we_i,
   input  logic [CNT_W-1:0] cnt_wdata_i,
   input  logic [CNT_W-1:0] load_i,
   input  logic             reload_i,
   output logic [CNT_W-1:0] count_o,
   output logic             run_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] ONES      = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] START_MAX = ONES - CNT_W'(MIN_DELTA);

   logic [CNT_W-1:0] count_q;
   logic             run_q;
   logic [CNT_W-1:0] start_val;
   logic             step;

   generate
      if (MIN_DELTA == 0) begin : g_noclamp
         assign start_val = load_i;
      end else begin : g_clamp
         assign start_val = (load_i > START_MAX) ? START_MAX : load_i;
      end
   endgenerate

   assign step   = run_q & tick_i & ~ctrl_we_i & ~cnt_we_i;
   assign wrap_o = step & (count_q == ONES);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
         run_q   <= 1'b0;
      end else if (ctrl_we_i) begin
         run_q <= run_wdata_i;
         if (trig_i) count_q <= start_val;
      end else if (cnt_we_i) begin
         count_q <= cnt_wdata_i;
      end else if (wrap_o) begin
         if (reload_i) begin
            count_q <= load_i;
         end else begin
            count_q <= '0;
            run_q   <= 1'b0;
         end
      end else if (step) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count_o = count_q;
   assign run_o   = run_q;

   AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && tick_i && !ctrl_we_i && !cnt_we_i && count_q != ONES) |=> count_q == $past(count_q) + 1'b1); // R2
   AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q && !ctrl_we_i && !cnt_we_i) |=> $stable(count_q)); // R2
   AST_ONESHOT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap_o && !reload_i) |=> (!run_q && count_q == '0)); // R4
   AST_RELOAD_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap_o && reload_i) |=> (run_q && count_q == $past(load_i))); // R5
   AST_START_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_we_i && trig_i) |=> count_q <= START_MAX); // R8
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
   import evt_timer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CNT_W-1:0]  wdata_i,
   input  logic              wrap_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              run_i,
   output logic              ctrl_we_o,
   output logic              run_wdata_o,
   output logic              trig_o,
   output logic              cnt_we_o,
   output logic [CNT_W-1:0]  load_o,
   output logic              reload_o,
   output logic              stat_o,
   output logic              ien_o,
   output logic [CNT_W-1:0]  rdata_o
);
   logic [CNT_W-1:0] load_q;
   logic             reload_q;
   logic             stat_q;
   logic             ien_q;
   logic             load_we, stat_we, ien_we;

   always_comb begin
      ctrl_we_o = 1'b0;
      load_we   = 1'b0;
      cnt_we_o  = 1'b0;
      stat_we   = 1'b0;
      ien_we    = 1'b0;
      if (wr_en_i) begin
         case (reg_addr_e'(addr_i))
            A_CTRL:   ctrl_we_o = 1'b1;
            A_LOAD:   load_we   = 1'b1;
            A_COUNT:  cnt_we_o  = 1'b1;
            A_STATUS: stat_we   = 1'b1;
            A_IEN:    ien_we    = 1'b1;
            default:  ;
         endcase
      end
   end

   assign run_wdata_o = wdata_i[CTRL_RUN_BIT];
   assign trig_o      = wdata_i[CTRL_TRIG_BIT];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         load_q   <= '0;
         reload_q <= 1'b0;
         stat_q   <= 1'b0;
         ien_q    <= 1'b0;
      end else begin
         if (load_we)   load_q   <= wdata_i;
         if (ctrl_we_o) reload_q <= wdata_i[CTRL_RELOAD_BIT];
         if (ien_we)    ien_q    <= wdata_i[IEN_OVF_BIT];
         if (wrap_i)
            stat_q <= 1'b1;
         else if (stat_we && wdata_i[STAT_OVF_BIT])
            stat_q <= 1'b0;
      end
   end

   always_comb begin
      rdata_o = '0;
      case (reg_addr_e'(addr_i))
         A_CTRL: begin
            rdata_o[CTRL_RUN_BIT]    = run_i;
            rdata_o[CTRL_RELOAD_BIT] = reload_q;
         end
         A_LOAD:   rdata_o = load_q;
         A_COUNT:  rdata_o = count_i;
         A_STATUS: rdata_o[STAT_OVF_BIT] = stat_q;
         A_IEN:    rdata_o[IEN_OVF_BIT]  = ien_q;
         default:  rdata_o = '0;
      endcase
   end

   assign load_o   = load_q;
   assign reload_o = reload_q;
   assign stat_o   = stat_q;
   assign ien_o    = ien_q;

   AST_OVF_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_i |=> stat_q); // R3
   AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_we && wdata_i[STAT_OVF_BIT] && !wrap_i) |=> !stat_q); // R9
   AST_LOAD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_we |=> ($stable(reload_q) && $stable(ien_q))); // R6
endmodule

// File: rtl/evt_timer32.sv
module evt_timer32
   import evt_timer_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int MIN_DELTA = 3,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CNT_W-1:0]  wdata_i,
   output logic [CNT_W-1:0]  rdata_o,
   output logic              irq_o
);
   generate
      if (CNT_W < 8 || CNT_W > 64) begin : g_bad_width
         $error("evt_timer32: CNT_W must lie in 8..64");
      end
      if (MIN_DELTA < 0 || MIN_DELTA > 255) begin : g_bad_delta
         $error("evt_timer32: MIN_DELTA must lie in 0..255");
      end
   endgenerate

   logic             ctrl_we, run_wdata, trig, cnt_we;
   logic [CNT_W-1:0] load, count;
   logic             reload, run, wrap, stat, ien;
   logic             irq_raw;

   evt_timer_regs #(.CNT_W(CNT_W)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i),
      .addr_i      (addr_i),
      .wdata_i     (wdata_i),
      .wrap_i      (wrap),
      .count_i     (count),
      .run_i       (run),
      .ctrl_we_o   (ctrl_we),
      .run_wdata_o (run_wdata),
      .trig_o      (trig),
      .cnt_we_o    (cnt_we),
      .load_o      (load),
      .reload_o    (reload),
      .stat_o      (stat),
      .ien_o       (ien),
      .rdata_o     (rdata_o)
   );

   evt_timer_core #(.CNT_W(CNT_W), .MIN_DELTA(MIN_DELTA)) u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i),
      .ctrl_we_i   (ctrl_we),
      .run_wdata_i (run_wdata),
      .trig_i      (trig),
      .cnt_we_i    (cnt_we),
      .cnt_wdata_i (wdata_i),
      .load_i      (load),
      .reload_i    (reload),
      .count_o     (count),
      .run_o       (run),
      .wrap_o      (wrap)
   );

   assign irq_raw = stat & ien;

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) irq_q <= 1'b0;
            else         irq_q <= irq_raw;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = irq_raw;
      end
   endgenerate

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !IRQ_REG) |-> (ien && stat)); // R10
   AST_IRQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!IRQ_REG && stat && ien && !wr_en_i) |=> irq_o); // R10
endmodule

// File: tb/evt_timer32_tb.sv
module evt_timer32_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [31:0] ONES = 32'hFFFF_FFFF;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        tick_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [2:0]  addr_i = 3'd0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;

   evt_timer32 dut_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .wr_en_i (wr_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .rdata_o (rdata_o),
      .irq_o   (irq_o)
   );

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk_i);
      wr_en_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk_i);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk_i);
      addr_i = a;
      #1 d = rdata_o;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk_i);
         tick_i = 1'b1;
      end
      @(negedge clk_i);
      tick_i = 1'b0;
   endtask

   task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] e);
      logic [31:0] v;
      rd(a, v);
      check(req, v, e);
   endtask

   task automatic t_reset;
      for (int a = 0; a < 8; a++) expect_reg("R1 reset reg", 3'(a), 32'd0);
      check("R1 irq at reset", {31'd0, irq_o}, 32'd0);
   endtask

   task automatic t_load_and_run;
      wr(3'd1, 32'd100);
      expect_reg("R6 count untouched", 3'd2, 32'd0);
      expect_reg("R6 ctrl untouched", 3'd0, 32'd0);
      expect_reg("R6 load value", 3'd1, 32'd100);
      wr(3'd0, 32'h5);
      expect_reg("R7 trigger copies load", 3'd2, 32'd100);
      expect_reg("R7 ctrl readback, trigger reads 0", 3'd0, 32'h1);
      ticks(5);
      expect_reg("R2 count after 5 ticks", 3'd2, 32'd105);
      wr(3'd0, 32'h0);
      ticks(3);
      expect_reg("R2 frozen when stopped", 3'd2, 32'd105);
      expect_reg("R2 load kept on stop", 3'd1, 32'd100);
      expect_reg("R2 status kept on stop", 3'd3, 32'd0);
   endtask

   task automatic t_oneshot;
      wr(3'd1, ONES - 32'd4);
      wr(3'd0, 32'h5);
      ticks(4);
      expect_reg("R3 no overflow before tick N+1", 3'd3, 32'd0);
      expect_reg("R3 count at all-ones", 3'd2, ONES);
      ticks(1);
      expect_reg("R3 overflow flag", 3'd3, 32'd1);
      expect_reg("R4 count zero after one-shot", 3'd2, 32'd0);
      expect_reg("R4 run cleared", 3'd0, 32'd0);
      ticks(2);
      expect_reg("R4 count stays after one-shot", 3'd2, 32'd0);
   endtask

   task automatic t_w1c;
      wr(3'd3, 32'd0);
      expect_reg("R9 write 0 no effect", 3'd3, 32'd1);
      wr(3'd3, 32'd1);
      expect_reg("R9 write 1 clears", 3'd3, 32'd0);
   endtask

   task automatic t_periodic;
      wr(3'd1, ONES - 32'd5);
      wr(3'd0, 32'h7);
      ticks(5);
      expect_reg("R5 no overflow before period", 3'd3, 32'd0);
      ticks(1);
      expect_reg("R5 overflow after P ticks", 3'd3, 32'd1);
      expect_reg("R5 reload copies load", 3'd2, ONES - 32'd5);
      wr(3'd3, 32'd1);
      ticks(6);
      expect_reg("R5 second period", 3'd3, 32'd1);
      ticks(3);
      expect_reg("R5 keeps counting", 3'd2, ONES - 32'd2);
      expect_reg("R5 run and reload kept", 3'd0, 32'h3);
      wr(3'd0, 32'h0);
      wr(3'd3, 32'd1);
   endtask

   task automatic t_clamp;
      wr(3'd1, ONES - 32'd1);
      wr(3'd0, 32'h5);
      expect_reg("R8 start clamped", 3'd2, ONES - 32'd3);
      expect_reg("R8 load keeps value", 3'd1, ONES - 32'd1);
      wr(3'd1, ONES - 32'd3);
      wr(3'd0, 32'h5);
      expect_reg("R8 boundary not clamped", 3'd2, ONES - 32'd3);
      ticks(3);
      expect_reg("R8 no overflow at all-ones", 3'd3, 32'd0);
      ticks(1);
      expect_reg("R8 overflow after delta+1", 3'd3, 32'd1);
   endtask

   task automatic t_irq;
      #1 check("R10 irq masked", {31'd0, irq_o}, 32'd0);
      wr(3'd4, 32'd1);
      #1 check("R10 irq when enabled", {31'd0, irq_o}, 32'd1);
      ticks(2);
      #1 check("R10 irq holds", {31'd0, irq_o}, 32'd1);
      wr(3'd4, 32'd0);
      #1 check("R10 irq drops with enable", {31'd0, irq_o}, 32'd0);
      wr(3'd4, 32'd1);
      wr(3'd3, 32'd1);
      #1 check("R10 irq drops on clear", {31'd0, irq_o}, 32'd0);
   endtask

   task automatic t_same_cycle;
      wr(3'd1, 32'd0);
      wr(3'd0, 32'h3);
      wr(3'd2, ONES);
      @(negedge clk_i);
      tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 3'd3; wdata_i = 32'd1;
      @(negedge clk_i);
      tick_i = 1'b0; wr_en_i = 1'b0;
      expect_reg("R9 set wins over clear", 3'd3, 32'd1);
      wr(3'd3, 32'd1);
   endtask

   task automatic t_freerun;
      wr(3'd1, 32'd0);
      wr(3'd0, 32'h7);
      wr(3'd2, ONES - 32'd1);
      expect_reg("R11 count write while running", 3'd2, ONES - 32'd1);
      ticks(2);
      expect_reg("R11 wraps to zero", 3'd2, 32'd0);
      expect_reg("R11 still running", 3'd0, 32'h3);
      ticks(4);
      expect_reg("R11 free-run continues", 3'd2, 32'd4);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      t_reset();
      t_load_and_run();
      t_oneshot();
      t_w1c();
      t_periodic();
      t_clamp();
      t_irq();
      t_same_cycle();
      t_freerun();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk_i);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule